// File: doc/BRIEF.md
# FIFO Write-Through Set-Associative Cache Bank

This block is one bank of a set-associative cache that sits between a requester and a slower lower level. The requester presents one load or store at a time on a 32-bit byte address with a size of one byte up to a whole block. The bank looks the address up in the set it selects and reports hit or miss. A load that misses fetches the whole block from the lower level and installs it. A store is always passed on to the lower level. A store that hits also updates the cached bytes. A store that misses leaves the cache contents as they were.

The geometry is fixed when the block is built. `SET_BITS` gives the number of sets as a power of two, and zero makes the bank fully associative. `WAYS` gives the lines per set. `OFF_BITS` gives the block size as a power of two, and must be at least 1. When a set is full, the victim is the line that was filled longest ago, whether or not it has been used since. The bank keeps free-running counts of hits, misses and evictions. The lower level is a plain request/response port: the bank raises one request pulse and then waits for one response pulse.

Top module: `fifo_cache`

## Requirements
- R1: After reset every line is invalid, all three counters read zero, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low.
- R2: Address bits [OFF_BITS-1:0] are the byte offset, the next SET_BITS bits pick the set, and the bits above are the tag. Lines in different sets never displace each other.
- R3: For a load that hits, `rsp_valid` is high with `rsp_hit`=1 one cycle after acceptance, and `rsp_rdata` holds the full cached block. No lower-level request is made.
- R4: For a load that misses, `mem_req_valid` pulses one cycle after acceptance with `mem_req_write`=0, a block-aligned `mem_req_addr` and all byte enables set. One cycle after `mem_rsp_valid`, `rsp_valid` rises with `rsp_hit`=0 and `rsp_rdata` equal to the returned block, and the block is installed.
- R5: On a miss fill, an invalid way of the set is used before any valid line is displaced.
- R6: When every way of the set is valid, the line filled earliest is replaced, even if it has been hit since.
- R7: On a store hit, only the bytes selected by the mask are updated. The mask has `req_size` consecutive bits set starting at bit = offset, and bit i covers `req_wdata[8i+7:8i]`. Later loads return the merged block.
- R8: Every store is forwarded one cycle after acceptance with `mem_req_write`=1, the request address, the byte mask of R7 on `mem_req_be` and `req_wdata` on `mem_req_wdata`. A store that misses installs nothing. The store's `rsp_valid` follows one cycle after `mem_rsp_valid`, with `rsp_hit` giving the lookup result.
- R9: `hit_count` and `miss_count` each rise by one per hit or miss at acceptance. `evict_count` rises by one only when a fill displaces a valid line.
- R10: `req_ready` stays low from acceptance of a miss or store until its response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank idle and accepting |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_size | input | OFF_BITS+1 | Byte count, 1 to 2^OFF_BITS |
| req_wdata | input | 8*2^OFF_BITS | Store data, byte i in lane i |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Lookup result of the answered request |
| rsp_rdata | output | 8*2^OFF_BITS | Block for a load |
| mem_req_valid | output | 1 | Lower-level request pulse |
| mem_req_write | output | 1 | 1 = forwarded store, 0 = block fill |
| mem_req_addr | output | 32 | Lower-level address |
| mem_req_be | output | 2^OFF_BITS | Byte enables |
| mem_req_wdata | output | 8*2^OFF_BITS | Forwarded store data |
| mem_rsp_valid | input | 1 | Lower-level completion pulse |
| mem_rsp_rdata | input | 8*2^OFF_BITS | Fill data |
| hit_count | output | CNT_W | Hits so far |
| miss_count | output | CNT_W | Misses so far |
| evict_count | output | CNT_W | Valid lines displaced so far |

## Verification
The bench builds the bank with two sets, two ways and 8-byte blocks. With this geometry a short directed sequence can fill a set, hit its oldest line and then force a third tag in. This shows that replacement follows fill order and not use. A 1 KiB window of random addresses packs many tags into each set, so evictions, store hits and store misses all occur often. Partial stores of 1, 2, 4 and 8 bytes at every aligned offset exercise each byte-mask shape of an 8-byte block.

// File: rtl/fifo_cache_pkg.sv
package fifo_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } cache_state_e;

    typedef struct packed {
        cache_state_e state;
        logic [31:0]  addr;
        logic         pend_hit;
        logic         rsp_valid;
        logic         rsp_hit;
        logic         mem_valid;
        logic         mem_write;
    } cache_ctrl_t;

endpackage

// File: rtl/fifo_cache_addr_split.sv
module fifo_cache_addr_split #(
    parameter int SET_BITS = 1,
    parameter int OFF_BITS = 3,
    parameter int IDX_W    = 1,
    parameter int TAG_W    = 28,
    parameter int BYTES    = 8
) (
    input  logic [31:0]       addr,
    input  logic [OFF_BITS:0] size,
    output logic [IDX_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag,
    output logic [BYTES-1:0]  byte_mask
);
    logic [OFF_BITS+1:0] first_byte;
    logic [OFF_BITS+1:0] end_byte;

    generate
        if (SET_BITS == 0) begin : g_full_assoc
            assign set_idx = '0;
        end else begin : g_indexed
            assign set_idx = addr[OFF_BITS +: SET_BITS];
        end
    endgenerate

    assign tag        = addr[31 -: TAG_W];
    assign first_byte = {2'b00, addr[OFF_BITS-1:0]};
    assign end_byte   = first_byte + {1'b0, size};

    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            byte_mask[i] = ((OFF_BITS+2)'(i) >= first_byte) &&
                           ((OFF_BITS+2)'(i) <  end_byte);
        end
    end
endmodule

// File: rtl/fifo_cache_tag_match.sv
module fifo_cache_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 28,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]            set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign match[w] = set_valid[w] && (set_tags[w] == tag);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/fifo_cache.sv
module fifo_cache #(
    parameter int SET_BITS = 1,
    parameter int WAYS     = 2,
    parameter int OFF_BITS = 3,
    parameter int CNT_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [31:0]               req_addr,
    input  logic [OFF_BITS:0]         req_size,
    input  logic [8*(1<<OFF_BITS)-1:0] req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [8*(1<<OFF_BITS)-1:0] rsp_rdata,
    output logic                      mem_req_valid,
    output logic                      mem_req_write,
    output logic [31:0]               mem_req_addr,
    output logic [(1<<OFF_BITS)-1:0]  mem_req_be,
    output logic [8*(1<<OFF_BITS)-1:0] mem_req_wdata,
    input  logic                      mem_rsp_valid,
    input  logic [8*(1<<OFF_BITS)-1:0] mem_rsp_rdata,
    output logic [CNT_W-1:0]          hit_count,
    output logic [CNT_W-1:0]          miss_count,
    output logic [CNT_W-1:0]          evict_count
);
    import fifo_cache_pkg::*;

    localparam int SETS   = 1 << SET_BITS;
    localparam int BYTES  = 1 << OFF_BITS;
    localparam int LINE_W = 8 * BYTES;
    localparam int TAG_W  = 32 - SET_BITS - OFF_BITS;
    localparam int IDX_W  = (SET_BITS > 0) ? SET_BITS : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LINES  = SETS * WAYS;

    cache_ctrl_t ctrl_d, ctrl_q;
    logic [SETS-1:0][WAYS-1:0]            valid_d, valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_d, tag_q;
    logic [SETS-1:0][WAY_W-1:0]           ptr_d, ptr_q;
    logic [LINE_W-1:0]                    data_d [LINES];
    logic [LINE_W-1:0]                    data_q [LINES];
    logic [LINE_W-1:0]                    rdata_d, rdata_q;
    logic [LINE_W-1:0]                    wdata_d, wdata_q;
    logic [BYTES-1:0]                     be_d, be_q;
    logic [CNT_W-1:0]                     hits_d, hits_q;
    logic [CNT_W-1:0]                     misses_d, misses_q;
    logic [CNT_W-1:0]                     evicts_d, evicts_q;

    // One split serves both the new request and the pending fill.
    logic [31:0]      look_addr;
    logic [IDX_W-1:0] look_set;
    logic [TAG_W-1:0] look_tag;
    logic [BYTES-1:0] look_mask;
    logic             look_hit;
    logic [WAY_W-1:0] look_way;
    logic [WAY_W-1:0] fill_way;
    int               hit_line;
    int               fill_line;

    assign look_addr = (ctrl_q.state == ST_IDLE) ? req_addr : ctrl_q.addr;

    fifo_cache_addr_split #(
        .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS), .IDX_W(IDX_W),
        .TAG_W(TAG_W), .BYTES(BYTES)
    ) u_split (
        .addr(look_addr), .size(req_size),
        .set_idx(look_set), .tag(look_tag), .byte_mask(look_mask)
    );

    fifo_cache_tag_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_match (
        .set_valid(valid_q[look_set]), .set_tags(tag_q[look_set]),
        .tag(look_tag), .hit(look_hit), .hit_way(look_way)
    );

    assign fill_way  = ptr_q[look_set];
    assign hit_line  = int'(look_set) * WAYS + int'(look_way);
    assign fill_line = int'(look_set) * WAYS + int'(fill_way);

    always_comb begin
        logic [LINE_W-1:0] merged;
        ctrl_d    = ctrl_q;
        valid_d   = valid_q;
        tag_d     = tag_q;
        ptr_d     = ptr_q;
        data_d    = data_q;
        rdata_d   = rdata_q;
        wdata_d   = wdata_q;
        be_d      = be_q;
        hits_d    = hits_q;
        misses_d  = misses_q;
        evicts_d  = evicts_q;
        merged    = data_q[hit_line];
        ctrl_d.rsp_valid = 1'b0;
        ctrl_d.mem_valid = 1'b0;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (look_hit) hits_d   = hits_q + 1'b1;
                    else          misses_d = misses_q + 1'b1;
                    if (req_write) begin
                        for (int i = 0; i < BYTES; i++) begin
                            if (look_mask[i]) merged[8*i +: 8] = req_wdata[8*i +: 8];
                        end
                        if (look_hit) data_d[hit_line] = merged;
                        ctrl_d.state     = ST_WRITE;
                        ctrl_d.addr      = req_addr;
                        ctrl_d.pend_hit  = look_hit;
                        ctrl_d.mem_valid = 1'b1;
                        ctrl_d.mem_write = 1'b1;
                        be_d             = look_mask;
                        wdata_d          = req_wdata;
                    end else if (look_hit) begin
                        ctrl_d.rsp_valid = 1'b1;
                        ctrl_d.rsp_hit   = 1'b1;
                        rdata_d          = data_q[hit_line];
                    end else begin
                        ctrl_d.state     = ST_FILL;
                        ctrl_d.addr      = {req_addr[31:OFF_BITS], {OFF_BITS{1'b0}}};
                        ctrl_d.mem_valid = 1'b1;
                        ctrl_d.mem_write = 1'b0;
                        be_d             = '1;
                    end
                end
            end
            ST_FILL: begin
                if (mem_rsp_valid) begin
                    if (valid_q[look_set][fill_way]) evicts_d = evicts_q + 1'b1;
                    valid_d[look_set][fill_way] = 1'b1;
                    tag_d[look_set][fill_way]   = look_tag;
                    data_d[fill_line]           = mem_rsp_rdata;
                    ptr_d[look_set] = (fill_way == WAY_W'(WAYS - 1)) ? '0 : fill_way + 1'b1;
                    ctrl_d.state     = ST_IDLE;
                    ctrl_d.rsp_valid = 1'b1;
                    ctrl_d.rsp_hit   = 1'b0;
                    rdata_d          = mem_rsp_rdata;
                end
            end
            ST_WRITE: begin
                if (mem_rsp_valid) begin
                    ctrl_d.state     = ST_IDLE;
                    ctrl_d.rsp_valid = 1'b1;
                    ctrl_d.rsp_hit   = ctrl_q.pend_hit;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            valid_q  <= '0;
            tag_q    <= '0;
            ptr_q    <= '0;
            rdata_q  <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            hits_q   <= '0;
            misses_q <= '0;
            evicts_q <= '0;
        end else begin
            ctrl_q   <= ctrl_d;
            valid_q  <= valid_d;
            tag_q    <= tag_d;
            ptr_q    <= ptr_d;
            rdata_q  <= rdata_d;
            wdata_q  <= wdata_d;
            be_q     <= be_d;
            hits_q   <= hits_d;
            misses_q <= misses_d;
            evicts_q <= evicts_d;
        end
    end

    // Line contents need no reset: valid bits guard them.
    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign req_ready     = (ctrl_q.state == ST_IDLE);
    assign rsp_valid     = ctrl_q.rsp_valid;
    assign rsp_hit       = ctrl_q.rsp_hit;
    assign rsp_rdata     = rdata_q;
    assign mem_req_valid = ctrl_q.mem_valid;
    assign mem_req_write = ctrl_q.mem_write;
    assign mem_req_addr  = ctrl_q.addr;
    assign mem_req_be    = be_q;
    assign mem_req_wdata = wdata_q;
    assign hit_count     = hits_q;
    assign miss_count    = misses_q;
    assign evict_count   = evicts_q;
endmodule

// File: rtl/fifo_cache_chk.sv
module fifo_cache_chk #(
    parameter int OFF_BITS = 3,
    parameter int CNT_W    = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       req_write,
    input logic                       rsp_valid,
    input logic                       mem_req_valid,
    input logic                       mem_req_write,
    input logic [31:0]                mem_req_addr,
    input logic [(1<<OFF_BITS)-1:0]   mem_req_be,
    input logic                       mem_rsp_valid,
    input logic [CNT_W-1:0]           hit_count,
    input logic [CNT_W-1:0]           miss_count,
    input logic [CNT_W-1:0]           evict_count
);
    // R3 / R4: a load ends either in an immediate response or a fill request.
    a_r3_load_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_write |=> (rsp_valid != mem_req_valid));

    a_r4_fill_whole_block: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write |->
            (&mem_req_be) && (mem_req_addr[OFF_BITS-1:0] == '0));

    a_r8_store_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write |=> mem_req_valid && mem_req_write);

    a_r9_counts_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(hit_count) && $stable(miss_count));

    a_r9_evict_only_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rsp_valid |=> $stable(evict_count));

    a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready && !mem_rsp_valid |=> !req_ready);

    a_r10_response_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
endmodule

bind fifo_cache fifo_cache_chk #(.OFF_BITS(OFF_BITS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_be(mem_req_be), .mem_rsp_valid(mem_rsp_valid),
    .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count)
);

// File: tb/test_fifo_cache.sv
module test_fifo_cache;
    localparam int SET_BITS = 1;
    localparam int WAYS     = 2;
    localparam int OFF_BITS = 3;
    localparam int CNT_W    = 16;
    localparam int SETS     = 1 << SET_BITS;
    localparam int BYTES    = 1 << OFF_BITS;
    localparam int LINE_W   = 8 * BYTES;
    localparam int MEM_SZ   = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [OFF_BITS:0] req_size = '0;
    logic [LINE_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_hit;
    logic [LINE_W-1:0] rsp_rdata;
    logic mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr;
    logic [BYTES-1:0] mem_req_be;
    logic [LINE_W-1:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_rdata = '0;
    logic [CNT_W-1:0] hit_count, miss_count, evict_count;

    always #2 clk = ~clk;

    fifo_cache #(.SET_BITS(SET_BITS), .WAYS(WAYS), .OFF_BITS(OFF_BITS), .CNT_W(CNT_W)) i_fifo_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count)
    );

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] mem [MEM_SZ];
    bit          rv [SETS][WAYS];
    int unsigned rt [SETS][WAYS];
    int          rstamp [SETS][WAYS];
    int          stamp_ctr = 0;
    int          exp_hit = 0, exp_miss = 0, exp_evict = 0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] mem_blk(logic [31:0] a);
        logic [LINE_W-1:0] r;
        int base = int'(a) & ~(BYTES - 1);
        for (int i = 0; i < BYTES; i++) r[8*i +: 8] = mem[(base + i) % MEM_SZ];
        return r;
    endfunction

    function automatic logic [BYTES-1:0] mask_of(logic [31:0] a, int size);
        logic [BYTES-1:0] m;
        int off = int'(a) & (BYTES - 1);
        for (int i = 0; i < BYTES; i++) m[i] = (i >= off) && (i < off + size);
        return m;
    endfunction

    function automatic int set_of(logic [31:0] a);
        return (int'(a) >> OFF_BITS) & (SETS - 1);
    endfunction

    function automatic int unsigned tag_of(logic [31:0] a);
        return a >> (OFF_BITS + SET_BITS);
    endfunction

    function automatic int ref_way(logic [31:0] a);
        int s = set_of(a);
        for (int w = 0; w < WAYS; w++)
            if (rv[s][w] && rt[s][w] == tag_of(a)) return w;
        return -1;
    endfunction

    // One access, with the lower level answered after a short delay.
    task automatic access(bit wr, logic [31:0] a, int size, logic [LINE_W-1:0] wd, string tagname);
        int hw = ref_way(a);
        bit hit = (hw >= 0);
        logic [BYTES-1:0] m = mask_of(a, size);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_size = (OFF_BITS+1)'(size); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) exp_hit++; else exp_miss++;
        if (!wr && hit) begin
            check({tagname, " R3 rsp_valid"}, 64'(rsp_valid), 64'd1);
            check({tagname, " R3 rsp_hit"}, 64'(rsp_hit), 64'd1);
            check({tagname, " R3 rdata"}, 64'(rsp_rdata), 64'(mem_blk(a)));
            check({tagname, " R3 no mem req"}, 64'(mem_req_valid), 64'd0);
        end else begin
            check({tagname, " R10 busy"}, 64'(req_ready), 64'd0);
            check({tagname, " R4/R8 mem req"}, 64'(mem_req_valid), 64'd1);
            check({tagname, " R4/R8 mem write"}, 64'(mem_req_write), 64'(wr));
            if (wr) begin
                check({tagname, " R8 addr"}, 64'(mem_req_addr), 64'(a));
                check({tagname, " R8 be"}, 64'(mem_req_be), 64'(m));
                check({tagname, " R8 wdata"}, 64'(mem_req_wdata), 64'(wd));
            end else begin
                check({tagname, " R4 addr"}, 64'(mem_req_addr), 64'(a & ~32'(BYTES - 1)));
                check({tagname, " R4 be"}, 64'(mem_req_be), 64'({BYTES{1'b1}}));
            end
            @(negedge clk);
            @(negedge clk);
            check({tagname, " R10 still busy"}, 64'(req_ready), 64'd0);
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = wr ? '0 : mem_blk(a);
            if (wr) begin
                for (int i = 0; i < BYTES; i++)
                    if (m[i]) mem[((int'(a) & ~(BYTES - 1)) + i) % MEM_SZ] = wd[8*i +: 8];
            end else begin
                int s = set_of(a);
                int v = -1;
                for (int w = WAYS - 1; w >= 0; w--) if (!rv[s][w]) v = w;
                if (v < 0) begin
                    v = 0;
                    for (int w = 1; w < WAYS; w++) if (rstamp[s][w] < rstamp[s][v]) v = w;
                    exp_evict++;
                end
                rv[s][v] = 1'b1; rt[s][v] = tag_of(a); rstamp[s][v] = stamp_ctr++;
            end
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            check({tagname, " R4/R8 rsp_valid"}, 64'(rsp_valid), 64'd1);
            check({tagname, " R4/R8 rsp_hit"}, 64'(rsp_hit), 64'(wr && hit));
            if (!wr) check({tagname, " R4 fill data"}, 64'(rsp_rdata), 64'(mem_blk(a)));
        end
        check({tagname, " R9 hits"}, 64'(hit_count), 64'(exp_hit));
        check({tagname, " R9 misses"}, 64'(miss_count), 64'(exp_miss));
        check({tagname, " R9 evictions"}, 64'(evict_count), 64'(exp_evict));
    endtask

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [LINE_W-1:0] full;
        void'($urandom(32'd1234));
        for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'(i * 7 + 3);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin rv[s][w] = 0; rt[s][w] = 0; rstamp[s][w] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        check("R1 counters", 64'({hit_count, miss_count, evict_count}), 64'd0);

        // R5: two tags into set 0 take both invalid ways without eviction.
        access(0, 32'h000, 8, '0, "R5 fill way a");
        access(0, 32'h020, 8, '0, "R5 fill way b");
        check("R5 no eviction yet", 64'(evict_count), 64'd0);
        access(0, 32'h004, 4, '0, "R3 hit");
        // R6: the hit line is still the oldest and goes first.
        access(0, 32'h040, 8, '0, "R6 third tag");
        access(0, 32'h000, 2, '0, "R6 oldest gone");
        access(0, 32'h040, 1, '0, "R6 survivor");
        // R2: set 1 does not disturb set 0.
        access(0, 32'h008, 8, '0, "R2 other set");
        access(0, 32'h040, 8, '0, "R2 set0 kept");
        // R8: store miss installs nothing.
        access(1, 32'h102, 2, 64'h0000_0000_beef_0000, "R8 store miss");
        check("R8 line absent", 64'(ref_way(32'h100) < 0), 64'd1);
        access(0, 32'h100, 8, '0, "R8 reload misses");
        // R7: partial store hit merges bytes.
        access(1, 32'h105, 1, 64'h0000_5a00_0000_0000, "R7 store hit");
        access(0, 32'h100, 8, '0, "R7 merged read");
        access(1, 32'h100, 8, 64'h0123_4567_89ab_cdef, "R7 full store");
        access(0, 32'h100, 8, '0, "R7 full read");

        for (int k = 0; k < 600; k++) begin
            int szl = int'($urandom % 4);
            int size = 1 << szl;
            logic [31:0] a = 32'($urandom % MEM_SZ) & ~32'(size - 1);
            bit wr = ($urandom % 3) == 0;
            full = {$urandom, $urandom};
            access(wr, a, size, full, wr ? "R7/R8 random store" : "R6/R9 random load");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule